// File: doc/BRIEF.md
# Programmable Stream Crossbar with Chainable FIFOs

The block is a configurable switch for 32-bit ready/valid streams carrying a last-beat flag. A set of external input ports and a set of external output ports meet two on-chip 16-entry buffers. Each buffer appears to the switch both as a destination (its write side) and as a source (its read side). Every destination holds its own route setting, written through a small write-only port. The setting is one of three: off, a fixed connection to one source, or packet routing by ID.

In fixed-connection mode a destination takes every beat of its chosen source. In packet mode, the low bits of the first beat of a packet name the destination. The destination then stays bound to the winning source until the beat flagged last has passed. When sources compete, the choice rotates, and it only changes at packet boundaries.

Pointing the second buffer's write side at the first buffer's read side gives one buffer of twice the depth. Order and the last flags are kept.

Top module: `stream_xbar`

## Requirements
- R1: Each port carries a 32-bit word plus a last flag. A beat moves only on a clock edge where valid and ready are both high, and it reaches the destination with its word and last flag unchanged. External outputs are driven from a register.
- R2: A stalled external output keeps valid high and its word stable until it is accepted, and it stalls the source feeding it without losing or duplicating any beat.
- R3: A route word is written as `{id, src, mode}`, with mode in bits [1:0] (0 off, 1 fixed, 2 packet), the source index directly above it, and the 5-bit ID in the top bits. `cfg_addr` selects the destination. In fixed mode any destination can take any source.
- R4: In packet mode a source's first pending beat is a header. Its bits [4:0] are compared with each packet destination's ID, and the header is forwarded along with the rest of the packet. The destination stays bound to that source until a beat with last set has been forwarded.
- R5: Competing sources for one packet destination are served round-robin by source index, starting after the last winner. Source 0 is favoured after reset. Packets are never interleaved.
- R6: A destination that is off keeps its valid low. A source that no destination takes keeps its ready low, so its beat waits.
- R7: A written route takes effect only once the destination is idle: not bound to a packet, no beat offered to it, and, for an external output, its register empty.
- R8: Each buffer holds 16 beats in order and reports full and empty. When full it refuses writes, and when empty it offers nothing.
- R9: Routing buffer 0's read side into buffer 1 gives a single in-order buffer of 32 beats. With the external output stalled, an input feeding this chain accepts exactly 33 beats, counting the output register.
- R10: Source indices are the external inputs 0..N_IN-1, then buffer 0 and buffer 1. Destination indices are the external outputs 0..N_OUT-1, then buffer 0 and buffer 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Route word write strobe |
| cfg_addr | input | DST_W | Destination index of the route word |
| cfg_wdata | input | CFG_W | Route word {id, src, mode} |
| s_tvalid | input | N_IN | Input valid, one per input port |
| s_tready | output | N_IN | Input ready |
| s_tdata | input | N_IN*DATA_W | Input words, port i at bits i*DATA_W |
| s_tlast | input | N_IN | Input last flag |
| m_tvalid | output | N_OUT | Output valid |
| m_tready | input | N_OUT | Output ready |
| m_tdata | output | N_OUT*DATA_W | Output words |
| m_tlast | output | N_OUT | Output last flag |
| fifo_full | output | 2 | Buffer full flags |
| fifo_empty | output | 2 | Buffer empty flags |

## Verification
The bench uses the default build: two inputs, two outputs, 16-entry buffers and 5-bit IDs. This gives four sources and four destinations. Every fixed route from an external input to an external output is swept under three ready patterns. At this size the exact fill counts of one buffer (17) and of the chain (33) are small enough to check beat by beat. The exact round-robin order of two sources sending two packets each can also be written out by hand.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  typedef enum logic [1:0] {
    RT_OFF  = 2'd0,
    RT_CIRC = 2'd1,
    RT_PKT  = 2'd2
  } route_mode_e;
endpackage

// File: rtl/xbar_route_cfg.sv
module xbar_route_cfg #(
  parameter int NDST  = 4,
  parameter int SRC_W = 2,
  parameter int ID_W  = 5,
  localparam int DST_W = (NDST > 1) ? $clog2(NDST) : 1,
  localparam int CFG_W = 2 + SRC_W + ID_W
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        we_i,
  input  logic [DST_W-1:0]            addr_i,
  input  logic [CFG_W-1:0]            wdata_i,
  input  logic [NDST-1:0]             idle_i,
  output logic [NDST-1:0][1:0]        mode_o,
  output logic [NDST-1:0][SRC_W-1:0]  src_o,
  output logic [NDST-1:0][ID_W-1:0]   id_o
);
  import xbar_pkg::*;

  for (genvar d = 0; d < NDST; d++) begin : g_dst
    logic             pend_q;
    logic [CFG_W-1:0] shadow_q;
    logic             apply;

    assign apply = pend_q && idle_i[d];

    always_ff @(posedge clk) begin
      if (rst) begin
        pend_q    <= 1'b0;
        shadow_q  <= '0;
        mode_o[d] <= RT_OFF;
        src_o[d]  <= '0;
        id_o[d]   <= '0;
      end else begin
        if (we_i && addr_i == DST_W'(d)) begin
          pend_q   <= 1'b1;
          shadow_q <= wdata_i;
        end else if (apply) begin
          pend_q <= 1'b0;
        end
        if (apply) begin
          {id_o[d], src_o[d], mode_o[d]} <= shadow_q;
        end
      end
    end
  end
endmodule

// File: rtl/xbar_pkt_lock.sv
module xbar_pkt_lock #(
  parameter int NSRC  = 4,
  parameter int SRC_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic [NSRC-1:0]  req_i,
  input  logic             done_i,
  output logic             locked_o,
  output logic [SRC_W-1:0] lock_src_o
);
  logic [SRC_W-1:0] rr_q;
  logic [SRC_W-1:0] win;
  logic             found;

  always_comb begin
    win   = '0;
    found = 1'b0;
    for (int k = 0; k < NSRC; k++) begin
      if (!found && req_i[(int'(rr_q) + k) % NSRC]) begin
        found = 1'b1;
        win   = SRC_W'((int'(rr_q) + k) % NSRC);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      locked_o   <= 1'b0;
      lock_src_o <= '0;
      rr_q       <= '0;
    end else if (!locked_o) begin
      if (en_i && found) begin
        locked_o   <= 1'b1;
        lock_src_o <= win;
        rr_q       <= (int'(win) == NSRC - 1) ? '0 : win + 1'b1;
      end
    end else if (done_i || !en_i) begin
      locked_o <= 1'b0;
    end
  end

  p_no_interleave_r5: assert property (@(posedge clk) disable iff (rst)
    (locked_o && !done_i && en_i) |=> (locked_o && $stable(lock_src_o)));

  p_grant_requested_r5: assert property (@(posedge clk) disable iff (rst)
    (!locked_o && en_i && |req_i) |=> locked_o);
endmodule

// File: rtl/xbar_fifo.sv
module xbar_fifo #(
  parameter int W     = 33,
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_valid_i,
  input  logic [W-1:0] wr_data_i,
  output logic         wr_ready_o,
  output logic         rd_valid_o,
  output logic [W-1:0] rd_data_o,
  input  logic         rd_ready_i,
  output logic         full_o,
  output logic         empty_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          wr_fire, rd_fire;

  assign full_o     = (cnt_q == CW'(DEPTH));
  assign empty_o    = (cnt_q == '0);
  assign wr_ready_o = !full_o;
  assign rd_valid_o = !empty_o;
  assign rd_data_o  = mem[rp_q];
  assign wr_fire    = wr_valid_i && wr_ready_o;
  assign rd_fire    = rd_valid_o && rd_ready_i;

  always_ff @(posedge clk) begin
    if (wr_fire) mem[wp_q] <= wr_data_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_fire) wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (rd_fire) rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      case ({wr_fire, rd_fire})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  p_full_holds_r8: assert property (@(posedge clk) disable iff (rst)
    (full_o && !rd_fire) |=> full_o);

  p_empty_holds_r8: assert property (@(posedge clk) disable iff (rst)
    (empty_o && !wr_valid_i) |=> (empty_o && !rd_valid_o));
endmodule

// File: rtl/xbar_out_stage.sv
module xbar_out_stage #(
  parameter int W = 33
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid_i,
  input  logic [W-1:0] in_data_i,
  output logic         in_ready_o,
  output logic         out_valid_o,
  output logic [W-1:0] out_data_o,
  input  logic         out_ready_i
);
  assign in_ready_o = !out_valid_o || out_ready_i;

  always_ff @(posedge clk) begin
    if (rst) out_valid_o <= 1'b0;
    else if (in_ready_o) out_valid_o <= in_valid_i;
  end

  always_ff @(posedge clk) begin
    if (in_ready_o && in_valid_i) out_data_o <= in_data_i;
  end

  p_hold_stalled_r2: assert property (@(posedge clk) disable iff (rst)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));
endmodule

// File: rtl/stream_xbar.sv
module stream_xbar #(
  parameter int N_IN       = 2,
  parameter int N_OUT      = 2,
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 16,
  parameter int ID_W       = 5,
  localparam int NSRC   = N_IN + 2,
  localparam int NDST   = N_OUT + 2,
  localparam int SRC_W  = $clog2(NSRC),
  localparam int DST_W  = $clog2(NDST),
  localparam int CFG_W  = 2 + SRC_W + ID_W,
  localparam int BEAT_W = DATA_W + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_we,
  input  logic [DST_W-1:0]        cfg_addr,
  input  logic [CFG_W-1:0]        cfg_wdata,
  input  logic [N_IN-1:0]         s_tvalid,
  output logic [N_IN-1:0]         s_tready,
  input  logic [N_IN*DATA_W-1:0]  s_tdata,
  input  logic [N_IN-1:0]         s_tlast,
  output logic [N_OUT-1:0]        m_tvalid,
  input  logic [N_OUT-1:0]        m_tready,
  output logic [N_OUT*DATA_W-1:0] m_tdata,
  output logic [N_OUT-1:0]        m_tlast,
  output logic [1:0]              fifo_full,
  output logic [1:0]              fifo_empty
);
  import xbar_pkg::*;

  logic [NSRC-1:0]              src_valid, src_ready;
  logic [NSRC-1:0][BEAT_W-1:0]  src_beat;
  logic [NDST-1:0]              dst_valid, dst_ready, dst_idle;
  logic [NDST-1:0][BEAT_W-1:0]  dst_beat;

  logic [NDST-1:0][1:0]         cfg_mode;
  logic [NDST-1:0][SRC_W-1:0]   cfg_src;
  logic [NDST-1:0][ID_W-1:0]    cfg_id;

  logic [NDST-1:0]              locked;
  logic [NDST-1:0][SRC_W-1:0]   lock_src;
  logic [NDST-1:0][NSRC-1:0]    req;

  logic [NSRC-1:0]              circ_own, lock_own, pkt_hit;
  logic [NSRC-1:0][DST_W-1:0]   circ_dst, lock_dst, pkt_dst;

  xbar_route_cfg #(.NDST(NDST), .SRC_W(SRC_W), .ID_W(ID_W)) i_cfg (
    .clk(clk), .rst(rst), .we_i(cfg_we), .addr_i(cfg_addr), .wdata_i(cfg_wdata),
    .idle_i(dst_idle), .mode_o(cfg_mode), .src_o(cfg_src), .id_o(cfg_id)
  );

  // Sources: external inputs first, then the two buffer read sides.
  for (genvar i = 0; i < N_IN; i++) begin : g_src_port
    assign src_valid[i] = s_tvalid[i];
    assign src_beat[i]  = {s_tlast[i], s_tdata[i*DATA_W +: DATA_W]};
    assign s_tready[i]  = src_ready[i];
  end

  // Which destination each source belongs to this cycle; lowest index wins.
  always_comb begin
    for (int s = 0; s < NSRC; s++) begin
      circ_own[s] = 1'b0; circ_dst[s] = '0;
      lock_own[s] = 1'b0; lock_dst[s] = '0;
      pkt_hit[s]  = 1'b0; pkt_dst[s]  = '0;
      for (int d = NDST - 1; d >= 0; d--) begin
        if (cfg_mode[d] == RT_CIRC && cfg_src[d] == SRC_W'(s)) begin
          circ_own[s] = 1'b1;
          circ_dst[s] = DST_W'(d);
        end
        if (cfg_mode[d] == RT_PKT && locked[d] && lock_src[d] == SRC_W'(s)) begin
          lock_own[s] = 1'b1;
          lock_dst[s] = DST_W'(d);
        end
        if (cfg_mode[d] == RT_PKT && cfg_id[d] == src_beat[s][ID_W-1:0]) begin
          pkt_hit[s] = 1'b1;
          pkt_dst[s] = DST_W'(d);
        end
      end
    end
  end

  always_comb begin
    for (int d = 0; d < NDST; d++) begin
      for (int s = 0; s < NSRC; s++) begin
        req[d][s] = src_valid[s] && !circ_own[s] && !lock_own[s] &&
                    pkt_hit[s] && pkt_dst[s] == DST_W'(d);
      end
    end
  end

  always_comb begin
    for (int d = 0; d < NDST; d++) begin
      dst_valid[d] = 1'b0;
      dst_beat[d]  = src_beat[cfg_src[d]];
      if (cfg_mode[d] == RT_CIRC) begin
        dst_valid[d] = src_valid[cfg_src[d]] && circ_dst[cfg_src[d]] == DST_W'(d);
      end else if (cfg_mode[d] == RT_PKT && locked[d]) begin
        dst_beat[d]  = src_beat[lock_src[d]];
        dst_valid[d] = src_valid[lock_src[d]] && lock_own[lock_src[d]] &&
                       lock_dst[lock_src[d]] == DST_W'(d);
      end
    end
  end

  always_comb begin
    for (int s = 0; s < NSRC; s++) begin
      if (circ_own[s])      src_ready[s] = dst_ready[circ_dst[s]];
      else if (lock_own[s]) src_ready[s] = dst_ready[lock_dst[s]];
      else                  src_ready[s] = 1'b0;
    end
  end

  for (genvar d = 0; d < NDST; d++) begin : g_dst
    xbar_pkt_lock #(.NSRC(NSRC), .SRC_W(SRC_W)) i_lock (
      .clk(clk), .rst(rst),
      .en_i(cfg_mode[d] == RT_PKT),
      .req_i(req[d]),
      .done_i(dst_valid[d] && dst_ready[d] && dst_beat[d][DATA_W]),
      .locked_o(locked[d]),
      .lock_src_o(lock_src[d])
    );

    if (d < N_OUT) begin : g_port
      logic [BEAT_W-1:0] obeat;
      xbar_out_stage #(.W(BEAT_W)) i_out (
        .clk(clk), .rst(rst),
        .in_valid_i(dst_valid[d]), .in_data_i(dst_beat[d]), .in_ready_o(dst_ready[d]),
        .out_valid_o(m_tvalid[d]), .out_data_o(obeat), .out_ready_i(m_tready[d])
      );
      assign m_tdata[d*DATA_W +: DATA_W] = obeat[DATA_W-1:0];
      assign m_tlast[d]  = obeat[DATA_W];
      assign dst_idle[d] = !locked[d] && !dst_valid[d] && !m_tvalid[d];

      p_off_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode[d] == RT_OFF) |-> !m_tvalid[d]);

      p_cfg_when_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable({cfg_mode[d], cfg_src[d], cfg_id[d]}) |-> !$past(m_tvalid[d]));
    end else begin : g_buf
      localparam int F = d - N_OUT;
      xbar_fifo #(.W(BEAT_W), .DEPTH(FIFO_DEPTH)) i_fifo (
        .clk(clk), .rst(rst),
        .wr_valid_i(dst_valid[d]), .wr_data_i(dst_beat[d]), .wr_ready_o(dst_ready[d]),
        .rd_valid_o(src_valid[N_IN + F]), .rd_data_o(src_beat[N_IN + F]),
        .rd_ready_i(src_ready[N_IN + F]),
        .full_o(fifo_full[F]), .empty_o(fifo_empty[F])
      );
      assign dst_idle[d] = !locked[d] && !dst_valid[d];
    end
  end

  for (genvar s = 0; s < N_IN; s++) begin : g_chk_in
    p_unrouted_waits_r6: assert property (@(posedge clk) disable iff (rst)
      (s_tvalid[s] && !s_tready[s]) |=> s_tvalid[s] || $past(!s_tvalid[s]));
  end
endmodule

// File: tb/test_stream_xbar.sv
module test_stream_xbar;
  localparam int DW = 32;
  localparam int NI = 2;
  localparam int NO = 2;
  localparam int QN = 512;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic              cfg_we = 1'b0;
  logic [1:0]        cfg_addr = '0;
  logic [8:0]        cfg_wdata = '0;
  logic [NI-1:0]     s_tvalid, s_tready, s_tlast;
  logic [NI*DW-1:0]  s_tdata;
  logic [NO-1:0]     m_tvalid, m_tready, m_tlast;
  logic [NO*DW-1:0]  m_tdata;
  logic [1:0]        fifo_full, fifo_empty;

  stream_xbar i_stream_xbar (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tdata(s_tdata), .s_tlast(s_tlast),
    .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata), .m_tlast(m_tlast),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty)
  );

  int vectors = 0;
  int errors  = 0;
  int cyc     = 0;

  logic [32:0] txq [NI][QN];
  int txn [NI] = '{0, 0};
  int txp [NI] = '{0, 0};
  logic [32:0] rxq [NO][QN];
  int rxn [NO] = '{0, 0};
  int rmode [NO] = '{0, 0};
  logic [NO-1:0] held_v = '0;
  logic [31:0]   held_d [NO];

  // Drive at the falling edge, sample 1 ns later; values then hold through the rising edge.
  always @(negedge clk) begin
    cyc = cyc + 1;
    for (int i = 0; i < NI; i++) begin
      s_tvalid[i] = !rst && (txp[i] < txn[i]);
      {s_tlast[i], s_tdata[i*DW +: DW]} = (txp[i] < txn[i]) ? txq[i][txp[i]] : 33'd0;
    end
    for (int o = 0; o < NO; o++) begin
      case (rmode[o])
        0:       m_tready[o] = 1'b1;
        1:       m_tready[o] = 1'b0;
        2:       m_tready[o] = (cyc % 3) != 0;
        default: m_tready[o] = (cyc % 5) == 0;
      endcase
    end
    #1;
    for (int o = 0; o < NO; o++) begin
      if (held_v[o]) begin
        vectors++;
        if (!m_tvalid[o] || m_tdata[o*DW +: DW] !== held_d[o]) begin
          errors++;
          $display("FAIL R2: out%0d stalled beat changed, got v=%0b %h expected v=1 %h",
                   o, m_tvalid[o], m_tdata[o*DW +: DW], held_d[o]);
        end
      end
      held_v[o] = m_tvalid[o] && !m_tready[o];
      held_d[o] = m_tdata[o*DW +: DW];
      if (m_tvalid[o] && m_tready[o]) begin
        if (rxn[o] < QN) rxq[o][rxn[o]] = {m_tlast[o], m_tdata[o*DW +: DW]};
        rxn[o] = rxn[o] + 1;
      end
    end
    for (int i = 0; i < NI; i++) begin
      if (s_tvalid[i] && s_tready[i]) txp[i] = txp[i] + 1;
    end
  end

  task automatic settle();
    @(negedge clk);
    #2;
  endtask

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic push(input int i, input logic [31:0] w, input logic last);
    txq[i][txn[i]] = {last, w};
    txn[i] = txn[i] + 1;
  endtask

  task automatic cfg(input int d, input int mode, input int src, input int id);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_addr  = 2'(d);
    cfg_wdata = {5'(id), 2'(src), 2'(mode)};
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic all_off();
    for (int d = 0; d < 4; d++) cfg(d, 0, 0, 0);
    repeat (3) @(posedge clk);
  endtask

  task automatic wait_rx(input int o, input int n, input int maxc);
    int g = 0;
    while (rxn[o] < n && g < maxc) begin
      @(posedge clk);
      g++;
    end
  endtask

  function automatic logic [31:0] pword(input int src, input int pk, input int k, input int id);
    return {4'hC, 4'(src), 8'(pk), 8'(k), 3'b000, 5'(id)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    vectors++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    int rms [3] = '{0, 2, 3};
    int base, tbase, tb1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    settle();
    // R6/R8: reset state
    chk("R6 reset m_tvalid", 64'(m_tvalid), 0);
    chk("R6 reset s_tready", 64'(s_tready), 0);
    chk("R8 reset fifo_empty", 64'(fifo_empty), 64'h3);
    chk("R8 reset fifo_full", 64'(fifo_full), 0);

    // R1/R2/R3: fixed routes, every input to every output, three ready patterns
    for (int d = 0; d < NO; d++) begin
      for (int s = 0; s < NI; s++) begin
        for (int r = 0; r < 3; r++) begin
          cfg(1 - d, 0, 0, 0);
          cfg(d, 1, s, 0);
          repeat (2) @(posedge clk);
          rmode[d] = rms[r];
          base = rxn[d];
          for (int k = 0; k < 20; k++)
            push(s, 32'h1000_0000 | (d << 20) | (s << 16) | (r << 8) | k, (k % 5) == 4);
          wait_rx(d, base + 20, 400);
          for (int k = 0; k < 20; k++)
            chk("R1 R3 fixed route beat", 64'(rxq[d][base + k]),
                64'({(k % 5) == 4, 32'h1000_0000 | (d << 20) | (s << 16) | (r << 8) | k}));
          settle();
          chk("R6 unrouted input ready", 64'(s_tready[1 - s]), 0);
          chk("R6 off output valid", 64'(m_tvalid[1 - d]), 0);
          rmode[d] = 0;
        end
      end
    end

    // R2: full stall holds the source after one beat is taken into the register
    cfg(1, 0, 0, 0);
    cfg(0, 1, 0, 0);
    repeat (2) @(posedge clk);
    rmode[0] = 1;
    tbase = txp[0];
    base  = rxn[0];
    for (int k = 0; k < 5; k++) push(0, 32'h2000_0000 | k, k == 4);
    repeat (10) @(posedge clk);
    settle();
    chk("R2 stalled source accepted", 64'(txp[0] - tbase), 1);
    chk("R2 stalled output valid", 64'(m_tvalid[0]), 1);
    rmode[0] = 0;
    wait_rx(0, base + 5, 100);
    for (int k = 0; k < 5; k++)
      chk("R2 stall no loss", 64'(rxq[0][base + k]), 64'({k == 4, 32'h2000_0000 | k}));

    // R7: a new route waits until the output drains
    rmode[0] = 1;
    base = rxn[0];
    tb1  = txp[1];
    push(0, 32'h3000_00A0, 1'b0);
    push(0, 32'h3000_00A1, 1'b1);
    for (int k = 0; k < 3; k++) push(1, 32'h3000_00B0 | k, k == 2);
    repeat (4) @(posedge clk);
    cfg(0, 1, 1, 0);
    repeat (4) @(posedge clk);
    settle();
    chk("R7 pending route input1 ready", 64'(s_tready[1]), 0);
    chk("R7 pending route input1 taken", 64'(txp[1] - tb1), 0);
    rmode[0] = 0;
    wait_rx(0, base + 5, 100);
    chk("R7 old route beat0", 64'(rxq[0][base]), 64'({1'b0, 32'h3000_00A0}));
    chk("R7 old route beat1", 64'(rxq[0][base + 1]), 64'({1'b1, 32'h3000_00A1}));
    for (int k = 0; k < 3; k++)
      chk("R7 new route beat", 64'(rxq[0][base + 2 + k]), 64'({k == 2, 32'h3000_00B0 | k}));

    // R4/R5: packet routing, two sources racing for output 1
    all_off();
    cfg(0, 2, 0, 3);
    cfg(1, 2, 0, 7);
    repeat (2) @(posedge clk);
    base = rxn[1];
    tbase = rxn[0];
    for (int k = 0; k < 3; k++) push(0, pword(0, 0, k, 7), k == 2);
    for (int k = 0; k < 2; k++) push(0, pword(0, 1, k, 7), k == 1);
    for (int k = 0; k < 2; k++) push(1, pword(1, 0, k, 7), k == 1);
    for (int k = 0; k < 4; k++) push(1, pword(1, 1, k, 7), k == 3);
    wait_rx(1, base + 11, 300);
    for (int k = 0; k < 3; k++)
      chk("R5 order in0 pkt0", 64'(rxq[1][base + k]), 64'({k == 2, pword(0, 0, k, 7)}));
    for (int k = 0; k < 2; k++)
      chk("R5 order in1 pkt0", 64'(rxq[1][base + 3 + k]), 64'({k == 1, pword(1, 0, k, 7)}));
    for (int k = 0; k < 2; k++)
      chk("R5 order in0 pkt1", 64'(rxq[1][base + 5 + k]), 64'({k == 1, pword(0, 1, k, 7)}));
    for (int k = 0; k < 4; k++)
      chk("R5 order in1 pkt1", 64'(rxq[1][base + 7 + k]), 64'({k == 3, pword(1, 1, k, 7)}));
    chk("R4 non-matching output untouched", 64'(rxn[0] - tbase), 0);

    // R6/R4: header with no matching ID waits; matching ID then delivers it
    base = rxn[0];
    for (int k = 0; k < 2; k++) push(1, pword(1, 2, k, 9), k == 1);
    repeat (6) @(posedge clk);
    settle();
    chk("R6 unmatched header ready", 64'(s_tready[1]), 0);
    chk("R6 unmatched header no output", 64'(m_tvalid), 0);
    cfg(0, 2, 0, 9);
    wait_rx(0, base + 2, 100);
    for (int k = 0; k < 2; k++)
      chk("R4 packet to id 9", 64'(rxq[0][base + k]), 64'({k == 1, pword(1, 2, k, 9)}));

    // R8: single buffer in the path, output stalled
    all_off();
    cfg(2, 1, 0, 0);
    cfg(0, 1, 2, 0);
    repeat (2) @(posedge clk);
    rmode[0] = 1;
    tbase = txp[0];
    base  = rxn[0];
    for (int k = 0; k < 20; k++) push(0, 32'h4000_0000 | k, (k % 4) == 3);
    repeat (40) @(posedge clk);
    settle();
    chk("R8 buffer plus register accepted", 64'(txp[0] - tbase), 17);
    chk("R8 full flags", 64'(fifo_full), 64'h1);
    chk("R8 empty flags", 64'(fifo_empty), 64'h2);
    rmode[0] = 0;
    wait_rx(0, base + 20, 200);
    for (int k = 0; k < 20; k++)
      chk("R8 buffer order", 64'(rxq[0][base + k]), 64'({(k % 4) == 3, 32'h4000_0000 | k}));
    settle();
    chk("R8 drained empty", 64'(fifo_empty), 64'h3);

    // R9/R10: chain buffer 0 into buffer 1
    all_off();
    cfg(2, 1, 0, 0);
    cfg(3, 1, 2, 0);
    cfg(0, 1, 3, 0);
    repeat (2) @(posedge clk);
    rmode[0] = 1;
    tbase = txp[0];
    base  = rxn[0];
    for (int k = 0; k < 40; k++) push(0, 32'h5000_0000 | k, (k % 7) == 6);
    repeat (80) @(posedge clk);
    settle();
    chk("R9 chain accepted", 64'(txp[0] - tbase), 33);
    chk("R9 both buffers full", 64'(fifo_full), 64'h3);
    rmode[0] = 0;
    wait_rx(0, base + 40, 300);
    for (int k = 0; k < 40; k++)
      chk("R9 R10 chain order", 64'(rxq[0][base + k]), 64'({(k % 7) == 6, 32'h5000_0000 | k}));

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule